// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block watches the control pins of a synchronous DRAM on every rising clock edge. It turns the strobe pattern into a named command and keeps a state record for each bank. The record covers idle, opening, open, read and write bursts with or without auto precharge, write recovery, closing and refresh. Each timed state has a down-counter that is loaded from programmable cycle counts. When the counter runs out, the bank moves on to its next state by itself.

Every command is checked against the current state of the bank it targets, or of every bank for device-wide commands. The check also covers the row-open time, the spacing between activates and the state timers. An illegal command leaves all bank state as it was, apart from timers that were already running, and raises a registered flag one cycle later. A controller or a monitor uses the tracker to see whether a command stream obeys the device rules. It does not model the array or the data bus.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: After reset every bank state field is idle, `illegal` is low, `cmdOut` shows deselect (0) and every `bankReady` bit is high. Bank b reports on `bankStateOut[4b+3:4b]` with these codes: idle 0, opening 1, open 2, read 3, read with auto precharge 4, write 5, write with auto precharge 6, write recovery 7, write recovery before auto precharge 8, closing 9, refresh 10.
- R2: The command sampled at an edge appears on `cmdOut` right after that edge. The code is formed from selN, rowStrobeN, colStrobeN, wrEnN:
  - selN high gives deselect 0.
  - LHHH gives no operation 1.
  - LLLL gives mode set 2.
  - LLLH gives refresh 3 when clkEn is high and self refresh 4 when clkEn is low.
  - LLHL gives precharge 5 with autoPre low and precharge-all 6 with autoPre high.
  - LLHH gives activate 7.
  - LHLL gives write 8, or 9 with autoPre high.
  - LHLH gives read 10, or 11 with autoPre high.
  - LHHL gives burst stop 12.
- R3: `illegal` and `cmdBank` are registered with each command. An illegal command changes no bank state, and the flag drops again with the next legal command.
- R4: A read or write to an idle bank is illegal. A read or write to a bank that is open, bursting or in write recovery is legal:
  - a read stays in state 3 for cfgBurst edges and then returns to open;
  - a write stays in state 5 for cfgBurst edges, then in state 7 for cfgWrRec edges, then returns to open;
  - a new read restarts the burst count.
- R5: An activate to a bank that is not idle is illegal. A legal activate holds the bank in state 1 for cfgRcd edges, after which it is open.
- R6: An activate issued fewer than cfgRrd edges after the previous accepted activate is illegal.
- R7: A precharge with autoPre low closes the bank on bankAddr for cfgRp edges, after which the bank is idle. It is illegal before cfgRas edges have passed since that bank's activate. A precharge to a bank that is reading cuts the read short.
- R8: A precharge with autoPre high closes every open bank. It is illegal if any bank is opening, in an auto-precharge state, in recovery or refreshing.
- R9: A read with auto precharge runs its burst, then closes by itself for cfgRp edges. Any other column or precharge command to that bank in the meantime is illegal.
- R10: A write with auto precharge runs its burst, then write recovery (state 8) for cfgWrRec edges, then closes by itself.
- R11: Mode set and refresh are legal only when all banks are idle. A refresh or self refresh puts every bank in state 10 for cfgRc edges.
- R12: Burst stop returns every reading or writing bank to open. It is illegal while any auto-precharge burst is running.
- R13: `bankReady[b]` is high when a command on the next edge would find bank b idle or open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| selN | input | 1 | Device select strobe, active low |
| rowStrobeN | input | 1 | Row strobe, active low |
| colStrobeN | input | 1 | Column strobe, active low |
| wrEnN | input | 1 | Write enable strobe, active low |
| clkEn | input | 1 | Clock enable, picks refresh or self refresh |
| bankAddr | input | BA_W | Target bank |
| autoPre | input | 1 | All-bank precharge or auto-precharge request |
| cfgRcd | input | CNT_W | Activate to column command, in cycles |
| cfgRp | input | CNT_W | Precharge time, in cycles |
| cfgRrd | input | CNT_W | Activate to activate spacing, in cycles |
| cfgRas | input | CNT_W | Minimum row open time, in cycles |
| cfgRc | input | CNT_W | Refresh duration, in cycles |
| cfgBurst | input | CNT_W | Burst duration, in cycles |
| cfgWrRec | input | CNT_W | Write recovery, in cycles |
| cmdOut | output | 4 | Registered decoded command |
| bankStateOut | output | 4*NUM_BANKS | Per-bank state codes |
| illegal | output | 1 | Registered illegal-command flag |
| cmdBank | output | BA_W | Bank field registered with the command |
| bankReady | output | NUM_BANKS | Per-bank ready indication |

## Verification
The bench first sweeps column commands, precharge and the remaining codes over every bank of an idle device. This separates the decoding from the legality check, because each code must come out right whether it is accepted or refused. It then runs a timed sequence with small cycle counts. Commands are placed exactly one edge before and on the edge where a limit expires, so that an off-by-one in the row-open, precharge, spacing and refresh timers shows up. Auto-precharge reads and writes, a restarted read, burst stop and an all-bank precharge that cuts a read are each followed edge by edge through their state codes.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

  typedef enum logic [3:0] {
    CMD_DESEL  = 4'd0,
    CMD_NOP    = 4'd1,
    CMD_MRS    = 4'd2,
    CMD_REF    = 4'd3,
    CMD_SREF   = 4'd4,
    CMD_PRE    = 4'd5,
    CMD_PREALL = 4'd6,
    CMD_ACT    = 4'd7,
    CMD_WR     = 4'd8,
    CMD_WRA    = 4'd9,
    CMD_RD     = 4'd10,
    CMD_RDA    = 4'd11,
    CMD_BST    = 4'd12
  } cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE     = 4'd0,
    ST_OPENING  = 4'd1,
    ST_OPEN     = 4'd2,
    ST_READ     = 4'd3,
    ST_READ_AP  = 4'd4,
    ST_WRITE    = 4'd5,
    ST_WRITE_AP = 4'd6,
    ST_WREC     = 4'd7,
    ST_WREC_AP  = 4'd8,
    ST_CLOSING  = 4'd9,
    ST_REFRESH  = 4'd10
  } bank_st_e;

  // Strobe from control to datapath for one bank: load a new state and its timer.
  typedef struct packed {
    logic     ld;
    bank_st_e nxt;
  } bank_strb_t;

  // State a timed bank moves to once its timer has run out.
  function automatic bank_st_e autoNext(input bank_st_e s, input logic rasDone);
    case (s)
      ST_OPENING, ST_READ, ST_WREC: autoNext = ST_OPEN;
      ST_WRITE:                     autoNext = ST_WREC;
      ST_WRITE_AP:                  autoNext = ST_WREC_AP;
      ST_READ_AP, ST_WREC_AP:       autoNext = rasDone ? ST_CLOSING : s;
      ST_CLOSING, ST_REFRESH:       autoNext = ST_IDLE;
      default:                      autoNext = s;
    endcase
  endfunction

endpackage

// File: rtl/sdram_trk_ctrl.sv
module sdram_trk_ctrl
  import sdram_trk_pkg::*;
#(
  parameter int NB   = 4,
  parameter int BA_W = 2
) (
  input  logic             selN,
  input  logic             rowStrobeN,
  input  logic             colStrobeN,
  input  logic             wrEnN,
  input  logic             clkEn,
  input  logic [BA_W-1:0]  bankAddr,
  input  logic             autoPre,
  input  bank_st_e         st [NB],
  input  logic [NB-1:0]    tmrZero,
  input  logic [NB-1:0]    rasZero,
  input  logic             rrdZero,
  output cmd_e             cmdNow,
  output logic             illNow,
  output bank_strb_t       strb [NB],
  output logic             rrdLd,
  output logic [NB-1:0]    readyNow
);

  bank_st_e      eff [NB];
  bank_st_e      nxt [NB];
  logic [NB-1:0] hit;
  logic [NB-1:0] isIdle, isAp, preOk, needPre, colOk;
  logic          legal;

  // Command decode from the active-low strobes.
  always_comb begin
    if (selN) begin
      cmdNow = CMD_DESEL;
    end else begin
      case ({rowStrobeN, colStrobeN, wrEnN})
        3'b000:  cmdNow = CMD_MRS;
        3'b001:  cmdNow = clkEn ? CMD_REF : CMD_SREF;
        3'b010:  cmdNow = autoPre ? CMD_PREALL : CMD_PRE;
        3'b011:  cmdNow = CMD_ACT;
        3'b100:  cmdNow = autoPre ? CMD_WRA : CMD_WR;
        3'b101:  cmdNow = autoPre ? CMD_RDA : CMD_RD;
        3'b110:  cmdNow = CMD_BST;
        default: cmdNow = CMD_NOP;
      endcase
    end
  end

  // Effective state: a bank whose timer has expired counts as already moved on.
  always_comb begin
    for (int b = 0; b < NB; b++) begin
      eff[b]      = tmrZero[b] ? autoNext(st[b], rasZero[b]) : st[b];
      isIdle[b]   = (eff[b] == ST_IDLE);
      isAp[b]     = (eff[b] == ST_READ_AP) || (eff[b] == ST_WRITE_AP);
      needPre[b]  = (eff[b] != ST_IDLE) && (eff[b] != ST_CLOSING);
      readyNow[b] = (eff[b] == ST_IDLE) || (eff[b] == ST_OPEN);
      case (eff[b])
        ST_IDLE, ST_CLOSING:         preOk[b] = 1'b1;
        ST_OPEN, ST_READ, ST_WRITE:  preOk[b] = rasZero[b];
        default:                     preOk[b] = 1'b0;
      endcase
      case (eff[b])
        ST_OPEN, ST_READ, ST_WRITE, ST_WREC: colOk[b] = 1'b1;
        default:                             colOk[b] = 1'b0;
      endcase
    end
  end

  // Legality and next-state selection.
  always_comb begin
    legal = 1'b1;
    rrdLd = 1'b0;
    for (int b = 0; b < NB; b++) begin
      nxt[b] = eff[b];
      hit[b] = 1'b0;
    end
    case (cmdNow)
      CMD_MRS: legal = &isIdle;
      CMD_REF, CMD_SREF: begin
        legal = &isIdle;
        if (legal) for (int b = 0; b < NB; b++) nxt[b] = ST_REFRESH;
      end
      CMD_PRE: begin
        legal = preOk[bankAddr];
        if (legal && needPre[bankAddr]) nxt[bankAddr] = ST_CLOSING;
      end
      CMD_PREALL: begin
        legal = &preOk;
        if (legal)
          for (int b = 0; b < NB; b++) if (needPre[b]) nxt[b] = ST_CLOSING;
      end
      CMD_ACT: begin
        legal = isIdle[bankAddr] && rrdZero;
        if (legal) begin
          nxt[bankAddr] = ST_OPENING;
          rrdLd         = 1'b1;
        end
      end
      CMD_RD, CMD_RDA, CMD_WR, CMD_WRA: begin
        legal = colOk[bankAddr];
        if (legal) begin
          hit[bankAddr] = 1'b1;
          case (cmdNow)
            CMD_RD:  nxt[bankAddr] = ST_READ;
            CMD_RDA: nxt[bankAddr] = ST_READ_AP;
            CMD_WR:  nxt[bankAddr] = ST_WRITE;
            default: nxt[bankAddr] = ST_WRITE_AP;
          endcase
        end
      end
      CMD_BST: begin
        legal = ~|isAp;
        if (legal)
          for (int b = 0; b < NB; b++)
            if ((eff[b] == ST_READ) || (eff[b] == ST_WRITE)) nxt[b] = ST_OPEN;
      end
      default: legal = 1'b1;
    endcase
    illNow = ~legal;
    for (int b = 0; b < NB; b++) begin
      strb[b].ld  = hit[b] || (nxt[b] != st[b]);
      strb[b].nxt = nxt[b];
    end
  end

endmodule

// File: rtl/sdram_trk_dp.sv
module sdram_trk_dp
  import sdram_trk_pkg::*;
#(
  parameter int NB    = 4,
  parameter int BA_W  = 2,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  bank_strb_t       strb [NB],
  input  logic             rrdLd,
  input  cmd_e             cmdNow,
  input  logic             illNow,
  input  logic [BA_W-1:0]  bankAddr,
  input  logic [CNT_W-1:0] cfgRcd,
  input  logic [CNT_W-1:0] cfgRp,
  input  logic [CNT_W-1:0] cfgRrd,
  input  logic [CNT_W-1:0] cfgRas,
  input  logic [CNT_W-1:0] cfgRc,
  input  logic [CNT_W-1:0] cfgBurst,
  input  logic [CNT_W-1:0] cfgWrRec,
  output bank_st_e         st [NB],
  output logic [NB-1:0]    tmrZero,
  output logic [NB-1:0]    rasZero,
  output logic             rrdZero,
  output cmd_e             cmdQ,
  output logic             illQ,
  output logic [BA_W-1:0]  bankQ
);

  // A state lasting N edges is loaded with N-1; zero means "moves on this edge".
  function automatic logic [CNT_W-1:0] minusOne(input logic [CNT_W-1:0] x);
    minusOne = (x == '0) ? '0 : x - 1'b1;
  endfunction

  for (genvar b = 0; b < NB; b++) begin : g_bank
    bank_st_e         stQ;
    logic [CNT_W-1:0] tmr, rasTmr, ldVal;

    always_comb begin
      case (strb[b].nxt)
        ST_OPENING:                               ldVal = minusOne(cfgRcd);
        ST_READ, ST_READ_AP, ST_WRITE, ST_WRITE_AP: ldVal = minusOne(cfgBurst);
        ST_WREC, ST_WREC_AP:                      ldVal = minusOne(cfgWrRec);
        ST_CLOSING:                               ldVal = minusOne(cfgRp);
        ST_REFRESH:                               ldVal = minusOne(cfgRc);
        default:                                  ldVal = '0;
      endcase
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stQ    <= ST_IDLE;
        tmr    <= '0;
        rasTmr <= '0;
      end else begin
        if (strb[b].ld) begin
          stQ <= strb[b].nxt;
          tmr <= ldVal;
        end else if (tmr != '0) begin
          tmr <= tmr - 1'b1;
        end
        if (strb[b].ld && (strb[b].nxt == ST_OPENING)) rasTmr <= minusOne(cfgRas);
        else if (rasTmr != '0)                         rasTmr <= rasTmr - 1'b1;
      end
    end

    assign st[b]      = stQ;
    assign tmrZero[b] = (tmr == '0);
    assign rasZero[b] = (rasTmr == '0);
  end

  logic [CNT_W-1:0] rrdTmr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rrdTmr <= '0;
      cmdQ   <= CMD_DESEL;
      illQ   <= 1'b0;
      bankQ  <= '0;
    end else begin
      if (rrdLd)              rrdTmr <= minusOne(cfgRrd);
      else if (rrdTmr != '0)  rrdTmr <= rrdTmr - 1'b1;
      cmdQ  <= cmdNow;
      illQ  <= illNow;
      bankQ <= bankAddr;
    end
  end

  assign rrdZero = (rrdTmr == '0);

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int CNT_W     = 4,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   selN,
  input  logic                   rowStrobeN,
  input  logic                   colStrobeN,
  input  logic                   wrEnN,
  input  logic                   clkEn,
  input  logic [BA_W-1:0]        bankAddr,
  input  logic                   autoPre,
  input  logic [CNT_W-1:0]       cfgRcd,
  input  logic [CNT_W-1:0]       cfgRp,
  input  logic [CNT_W-1:0]       cfgRrd,
  input  logic [CNT_W-1:0]       cfgRas,
  input  logic [CNT_W-1:0]       cfgRc,
  input  logic [CNT_W-1:0]       cfgBurst,
  input  logic [CNT_W-1:0]       cfgWrRec,
  output logic [3:0]             cmdOut,
  output logic [4*NUM_BANKS-1:0] bankStateOut,
  output logic                   illegal,
  output logic [BA_W-1:0]        cmdBank,
  output logic [NUM_BANKS-1:0]   bankReady
);

  bank_st_e             stW   [NUM_BANKS];
  bank_strb_t           strbW [NUM_BANKS];
  logic [NUM_BANKS-1:0] tmrZero, rasZero;
  logic                 rrdZero, rrdLd, illNow, illQ;
  cmd_e                 cmdNow, cmdQ;

  sdram_trk_ctrl #(.NB(NUM_BANKS), .BA_W(BA_W)) u_ctrl (
    .selN(selN), .rowStrobeN(rowStrobeN), .colStrobeN(colStrobeN), .wrEnN(wrEnN),
    .clkEn(clkEn), .bankAddr(bankAddr), .autoPre(autoPre),
    .st(stW), .tmrZero(tmrZero), .rasZero(rasZero), .rrdZero(rrdZero),
    .cmdNow(cmdNow), .illNow(illNow), .strb(strbW), .rrdLd(rrdLd), .readyNow(bankReady)
  );

  sdram_trk_dp #(.NB(NUM_BANKS), .BA_W(BA_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strbW), .rrdLd(rrdLd), .cmdNow(cmdNow),
    .illNow(illNow), .bankAddr(bankAddr),
    .cfgRcd(cfgRcd), .cfgRp(cfgRp), .cfgRrd(cfgRrd), .cfgRas(cfgRas),
    .cfgRc(cfgRc), .cfgBurst(cfgBurst), .cfgWrRec(cfgWrRec),
    .st(stW), .tmrZero(tmrZero), .rasZero(rasZero), .rrdZero(rrdZero),
    .cmdQ(cmdQ), .illQ(illQ), .bankQ(cmdBank)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_out
    assign bankStateOut[4*b +: 4] = stW[b];
  end

  assign cmdOut  = cmdQ;
  assign illegal = illQ;

endmodule

// File: rtl/sdram_trk_chk.sv
module sdram_trk_chk
  import sdram_trk_pkg::*;
#(
  parameter int NB   = 4,
  parameter int BA_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [3:0]        cmdOut,
  input logic [4*NB-1:0]   bankStateOut,
  input logic              illegal,
  input logic [BA_W-1:0]   cmdBank,
  input logic [NB-1:0]     bankReady
);

  logic [3:0]    tgtSt;
  logic [NB-1:0] allRefresh, allClosedOrIdle;

  assign tgtSt = bankStateOut[{cmdBank, 2'b00} +: 4];

  for (genvar b = 0; b < NB; b++) begin : g_chk
    logic [3:0] s;
    assign s = bankStateOut[4*b +: 4];
    assign allRefresh[b]      = (s == ST_REFRESH);
    assign allClosedOrIdle[b] = (s == ST_IDLE) || (s == ST_CLOSING);

    // R3/R5/R11: an idle bank only leaves idle through an activate or a refresh
    a_r3_idle_exit: assert property (@(posedge clk) disable iff (!rstN)
      (s == ST_IDLE) |=> (s == ST_IDLE || s == ST_OPENING || s == ST_REFRESH));

    // R13: idle and open banks are always ready
    a_r13_ready_stable: assert property (@(posedge clk) disable iff (!rstN)
      (s == ST_IDLE || s == ST_OPEN) |-> bankReady[b]);
  end

  // R5: an accepted activate puts its bank in the opening state
  a_r5_act_enters: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOut == CMD_ACT && !illegal) |-> (tgtSt == ST_OPENING));

  // R4: an accepted read puts its bank in the read state
  a_r4_read_enters: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOut == CMD_RD && !illegal) |-> (tgtSt == ST_READ));

  // R9: an accepted auto-precharge read enters its own state
  a_r9_rda_enters: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOut == CMD_RDA && !illegal) |-> (tgtSt == ST_READ_AP));

  // R11: an accepted refresh puts every bank into refresh
  a_r11_refresh_all: assert property (@(posedge clk) disable iff (!rstN)
    ((cmdOut == CMD_REF || cmdOut == CMD_SREF) && !illegal) |-> (&allRefresh));

  // R8: after an accepted all-bank precharge no bank is left open
  a_r8_preall_closes: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOut == CMD_PREALL && !illegal) |-> (&allClosedOrIdle));

endmodule

bind sdram_cmd_tracker sdram_trk_chk #(.NB(NUM_BANKS), .BA_W(BA_W)) u_chk (
  .clk(clk), .rstN(rstN), .cmdOut(cmdOut), .bankStateOut(bankStateOut),
  .illegal(illegal), .cmdBank(cmdBank), .bankReady(bankReady)
);

// File: tb/sdram_cmd_tracker_bench.sv
module sdram_cmd_tracker_bench;

  localparam int CLK_P = 10;
  localparam int NB    = 4;
  localparam int BA_W  = 2;
  localparam int CW    = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic selN = 1'b1, rowStrobeN = 1'b1, colStrobeN = 1'b1, wrEnN = 1'b1;
  logic clkEn = 1'b1, autoPre = 1'b0;
  logic [BA_W-1:0] bankAddr = '0;
  logic [CW-1:0] cfgRcd = 4'd2, cfgRp = 4'd2, cfgRrd = 4'd2, cfgRas = 4'd5;
  logic [CW-1:0] cfgRc = 4'd4, cfgBurst = 4'd4, cfgWrRec = 4'd2;
  logic [3:0]    cmdOut;
  logic [4*NB-1:0] bankStateOut;
  logic          illegal;
  logic [BA_W-1:0] cmdBank;
  logic [NB-1:0] bankReady;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  sdram_cmd_tracker #(.NUM_BANKS(NB), .CNT_W(CW)) u_sdram_cmd_tracker (
    .clk(clk), .rstN(rstN), .selN(selN), .rowStrobeN(rowStrobeN),
    .colStrobeN(colStrobeN), .wrEnN(wrEnN), .clkEn(clkEn), .bankAddr(bankAddr),
    .autoPre(autoPre), .cfgRcd(cfgRcd), .cfgRp(cfgRp), .cfgRrd(cfgRrd),
    .cfgRas(cfgRas), .cfgRc(cfgRc), .cfgBurst(cfgBurst), .cfgWrRec(cfgWrRec),
    .cmdOut(cmdOut), .bankStateOut(bankStateOut), .illegal(illegal),
    .cmdBank(cmdBank), .bankReady(bankReady)
  );

  task automatic check(input string req, input int act, input int exp);
    checkCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chkSt(input string req, input int b, input int exp);
    check(req, int'(bankStateOut[4*b +: 4]), exp);
  endtask

  task automatic chkIll(input string req, input int exp, input int b);
    check(req, int'(illegal), exp);
    check(req, int'(cmdBank), b);
  endtask

  // Drive one command pattern and step past the sampling edge.
  task automatic send(input logic s, input logic r, input logic c, input logic w,
                      input int b, input logic ap, input logic ck);
    selN = s; rowStrobeN = r; colStrobeN = c; wrEnN = w;
    bankAddr = BA_W'(b); autoPre = ap; clkEn = ck;
    @(posedge clk); #1;
  endtask

  task automatic doNop();                         send(0,1,1,1,0,0,1); endtask
  task automatic doDesel();                       send(1,0,0,0,0,0,1); endtask
  task automatic doMrs();                         send(0,0,0,0,0,0,1); endtask
  task automatic doRef(input logic ck);           send(0,0,0,1,0,0,ck); endtask
  task automatic doPre(input int b, input logic all); send(0,0,1,0,b,all,1); endtask
  task automatic doAct(input int b);              send(0,0,1,1,b,0,1); endtask
  task automatic doWr(input int b, input logic ap); send(0,1,0,0,b,ap,1); endtask
  task automatic doRd(input int b, input logic ap); send(0,1,0,1,b,ap,1); endtask
  task automatic doBst();                         send(0,1,1,0,0,0,1); endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    check("R1 cmd", int'(cmdOut), 0);
    check("R1 illegal", int'(illegal), 0);
    check("R1 ready", int'(bankReady), 15);
    for (int b = 0; b < NB; b++) chkSt("R1 state", b, 0);

    // Sweep on an idle device: column commands refused, decode intact
    for (int b = 0; b < NB; b++) begin
      doRd(b, 0);  chkIll("R4 read idle", 1, b); check("R2 rd code", int'(cmdOut), 10); chkSt("R4", b, 0);
      doWr(b, 1);  chkIll("R4 write idle", 1, b); check("R2 wra code", int'(cmdOut), 9);
      doNop();     check("R3 clears", int'(illegal), 0); check("R2 nop code", int'(cmdOut), 1);
      doPre(b, 0); chkIll("R7 pre idle", 0, b); check("R2 pre code", int'(cmdOut), 5); chkSt("R7", b, 0);
    end
    doDesel(); check("R2 desel code", int'(cmdOut), 0);
    doBst();   check("R2 bst code", int'(cmdOut), 12); check("R12 bst idle", int'(illegal), 0);
    doMrs();   check("R2 mrs code", int'(cmdOut), 2);  check("R11 mrs idle", int'(illegal), 0);

    // E1..E8: activate timing, spacing, row-open time, precharge time
    doAct(0); check("R2 act code", int'(cmdOut), 7); chkSt("R5 opening", 0, 1);
    check("R13 not ready", int'(bankReady[0]), 0);
    doAct(1); chkIll("R6 spacing", 1, 1); chkSt("R6 bank1 idle", 1, 0); chkSt("R3 no change", 0, 1);
    check("R13 ready early", int'(bankReady[0]), 1);
    doAct(1); chkIll("R6 spaced ok", 0, 1); chkSt("R5 bank1", 1, 1); chkSt("R5 open", 0, 2);
    doAct(0); chkIll("R5 reopen", 1, 0); chkSt("R5 stays open", 0, 2);
    doPre(0, 0); chkIll("R7 ras short", 1, 0); chkSt("R7 still open", 0, 2);
    doPre(0, 0); chkIll("R7 ras met", 0, 0); chkSt("R7 closing", 0, 9);
    doAct(0); chkIll("R7 rp short", 1, 0); chkSt("R7 closing", 0, 9);
    doAct(0); chkIll("R7 rp met", 0, 0); chkSt("R7 reopen", 0, 1);

    // E9..E15: read with auto precharge on bank 1
    doRd(1, 1); check("R2 rda code", int'(cmdOut), 11); chkSt("R9 entry", 1, 4);
    doRd(1, 0); chkIll("R9 col during ap", 1, 1); chkSt("R9 held", 1, 4);
    doNop(); doNop(); chkSt("R9 burst", 1, 4);
    doNop(); chkSt("R9 auto close", 1, 9);
    doNop(); doNop(); chkSt("R9 idle", 1, 0); chkSt("R5 bank0 open", 0, 2);

    // E16..E21: read restart; E22..E28 write with recovery
    doRd(0, 0); chkSt("R4 read", 0, 3);
    doRd(0, 0); chkSt("R4 restart", 0, 3);
    doNop(); doNop(); doNop(); chkSt("R4 restarted burst", 0, 3);
    doNop(); chkSt("R4 read done", 0, 2);
    doWr(0, 0); check("R2 wr code", int'(cmdOut), 8); chkSt("R4 write", 0, 5);
    doNop(); doNop(); doNop(); chkSt("R4 write burst", 0, 5);
    doNop(); chkSt("R4 recovery", 0, 7);
    doNop(); doNop(); chkSt("R4 write done", 0, 2);

    // E29..E41: burst stop, write with auto precharge, blocked all-bank precharge
    doRd(0, 0); chkSt("R12 reading", 0, 3);
    doBst(); chkIll("R12 bst ok", 0, 0); chkSt("R12 stopped", 0, 2);
    doAct(2); chkSt("R5 bank2", 2, 1);
    doNop();
    doWr(2, 1); chkSt("R10 entry", 2, 6);
    doBst(); check("R12 bst during ap", int'(illegal), 1); chkSt("R12 bank0 kept", 0, 2);
    doPre(0, 1); check("R8 preall blocked", int'(illegal), 1); chkSt("R8 bank0 kept", 0, 2);
    doNop(); chkSt("R10 burst", 2, 6);
    doNop(); chkSt("R10 recovery", 2, 8);
    doNop(); doNop(); chkSt("R10 auto close", 2, 9);
    doNop(); doNop(); chkSt("R10 idle", 2, 0);

    // E42..E49: all-bank precharge cuts a read, mode set blocked, refresh
    doRd(0, 0); chkSt("R7 reading", 0, 3);
    doPre(1, 1); check("R2 preall code", int'(cmdOut), 6); check("R8 preall ok", int'(illegal), 0);
    chkSt("R8 cut read", 0, 9); chkSt("R8 idle kept", 1, 0);
    doMrs(); check("R11 mrs busy", int'(illegal), 1);
    doRef(1); check("R2 ref code", int'(cmdOut), 3); check("R11 ref ok", int'(illegal), 0);
    for (int b = 0; b < NB; b++) chkSt("R11 refresh", b, 10);
    check("R13 ready refresh", int'(bankReady), 0);
    doAct(3); chkIll("R11 act refresh", 1, 3);
    doNop(); check("R13 still busy", int'(bankReady), 0);
    doNop(); check("R13 ready edge", int'(bankReady), 15); chkSt("R11 still refresh", 3, 10);
    doNop(); for (int b = 0; b < NB; b++) chkSt("R11 idle", b, 0);

    // Self refresh with clock enable low
    doRef(0); check("R2 sref code", int'(cmdOut), 4); check("R11 sref ok", int'(illegal), 0);
    chkSt("R11 sref state", 2, 10);
    doNop(); doNop(); doNop(); doNop(); chkSt("R11 sref idle", 2, 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule